// File: doc/BRIEF.md
# Factorial Accelerator with Status Handshake

This block is a register-mapped engine that computes the factorial of a 32-bit operand with one multiply per clock. The host writes the operand into a single data register, and that write also starts the computation. The host then polls a busy flag in the status register, or waits for a completion request. When the engine is done, the host reads the result back from the same data register, because the result has overwritten the operand.

The status register also holds a sticky interrupt-enable flag. When this flag is set at the moment a computation finishes, the block sends a one-cycle request, carrying the interrupt code 0x00000001, toward an external interrupt aggregator. The bus protocol itself and interrupt delivery belong to the surrounding logic. Arithmetic is plain 32-bit wraparound.

Top module: `fact_accel`

## Requirements
- R1: After reset, a read of the data register (offset 0x08) returns 0, a read of the status register (offset 0x20) returns 0, and `irq_set` is 0.
- R2: A write to offset 0x08 while idle stores the operand and sets status bit 0 (busy) from the next cycle on. While busy, reads of 0x08 return the stored operand, not a partial product.
- R3: A write to offset 0x08 while busy is dropped: the stored value and the final result are unchanged.
- R4: The result is the product of all integers from the operand down to 1, truncated to 32 bits. An operand of 0 or 1 gives 1.
- R5: Busy stays set for exactly operand+1 cycles after the accepted write. It clears on the same edge that stores the result in the data register.
- R6: Writing offset 0x20 sets status bit 7 (interrupt enable) from wdata bit 7, or clears it. This write never changes the busy bit, whether the engine is idle or busy.
- R7: When a computation finishes while bit 7 is set, `irq_set` equals 0x00000001 for exactly one cycle, namely the cycle in which busy first reads 0. When bit 7 is clear, `irq_set` stays 0.
- R8: Reads of any other offset return 0. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| irq_set | output | 32 | Interrupt-status bits to set; 0x00000001 for one cycle on an enabled completion |

## Verification
An accepted operand write lands on one clock edge, and busy reads as 1 immediately after it. Busy then reads as 1 for exactly operand+1 edges. The result and the cleared busy flag appear together after the final edge, and the interrupt request is visible only in that same following cycle. The bench drives every access at the falling edge and samples the combinational read port just after it. It counts rising edges from the write until busy reads 0, so it can compare the exact latency, the data value and the single-cycle request against values computed from the operand.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam int BUSY_BIT = 0;
  localparam int IEN_BIT  = 7;
  localparam logic [DATA_W-1:0] IRQ_CODE = 32'h0000_0001;
endpackage

// File: rtl/fact_rst_sync.sv
module fact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/fact_core.sv
module fact_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic [DATA_W-1:0] data,
  output logic              finish
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              busy_q, busy_d;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign finish   = busy_q && cnt_zero;

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    data_d = data_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = operand;
      acc_d  = DATA_W'(1);
      data_d = operand;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_zero) begin
        data_d = acc_q;
        busy_d = 1'b0;
      end else begin
        acc_d = acc_q * cnt_q;
        cnt_d = cnt_q - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      data_q <= data_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign data = data_q;

  // R5: the edge with a zero counter ends the run
  a_r5_busy_ends: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && cnt_zero && !start) |=> !busy_q);
  // R2: the stored value is held while the product is still building
  a_r2_no_partial: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && !cnt_zero) |=> $stable(data_q));
  // R4: the counter only ever counts down during a run
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && !cnt_zero) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));
endmodule

// File: rtl/fact_csr.sv
module fact_csr
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] data,
  input  logic              finish,
  output logic              start,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] irq_set
);
  logic ien_q, ien_d;
  logic irq_q, irq_d;
  logic hit_data, hit_stat;

  assign hit_data = (addr == OFS_DATA);
  assign hit_stat = (addr == OFS_STAT);
  assign start    = we && hit_data && !busy;

  always_comb begin
    ien_d = ien_q;
    if (we && hit_stat) ien_d = wdata[IEN_BIT];
    irq_d = finish && ien_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_data) begin
      rdata = data;
    end else if (hit_stat) begin
      rdata[BUSY_BIT] = busy;
      rdata[IEN_BIT]  = ien_q;
    end
  end

  assign irq_set = irq_q ? IRQ_CODE : '0;

  // R7: request lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_q |=> !irq_q);
  // R7: request only follows a completion
  a_r7_after_finish: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_q |-> $past(finish));
endmodule

// File: rtl/fact_accel.sv
module fact_accel
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] irq_set
);
  logic              rst_ns;
  logic              start;
  logic              busy;
  logic              finish;
  logic [DATA_W-1:0] data;

  fact_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  fact_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .start   (start),
    .operand (reg_wdata),
    .busy    (busy),
    .data    (data),
    .finish  (finish)
  );

  fact_csr u_csr (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .busy    (busy),
    .data    (data),
    .finish  (finish),
    .start   (start),
    .rdata   (reg_rdata),
    .irq_set (irq_set)
  );

  // R2: accepted operand write raises busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_we && reg_addr == OFS_DATA && !busy) |=> busy);
  // R6: status write on an idle engine leaves it idle
  a_r6_keep_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_we && reg_addr == OFS_STAT && !busy) |=> !busy);
  // R3: busy write does not restart the counter path
  a_r3_drop_busy_write: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !finish && reg_we && reg_addr == OFS_DATA) |=> busy);
endmodule

// File: tb/tb_fact_accel.sv
module tb_fact_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_set;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fact_accel dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_set   (irq_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (logic [31:0] i = n; i > 0; i--) r = r * i;
    return r;
  endfunction

  // R2 R4 R5 R7: start, measure latency, check result and request
  task automatic run_fact(input logic [31:0] n, input bit ien);
    logic [31:0] v;
    int edges = 0;
    int irq_seen = 0;
    wr(8'h08, n);
    rd(8'h08, v);
    chk("R2 operand visible while busy", v, n);
    rd(8'h20, v);
    while (v[0] && edges < 200) begin
      if (irq_set != 0) irq_seen++;
      @(negedge clk);
      edges++;
      rd(8'h20, v);
    end
    chk("R5 busy length", 32'(edges), n + 1);
    chk("R7 request at completion", irq_set, ien ? 32'h1 : 32'h0);
    rd(8'h08, v);
    chk("R4 result", v, fact_ref(n));
    @(negedge clk);
    chk("R7 request one cycle", irq_set, 32'h0);
    chk("R7 no early request", 32'(irq_seen), 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h08, v); chk("R1 data after reset", v, 32'h0);
    rd(8'h20, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", irq_set, 32'h0);
  endtask

  task automatic t_busy_write;
    logic [31:0] v;
    wr(8'h08, 32'd6);
    wr(8'h08, 32'd3);
    rd(8'h08, v); chk("R3 busy write dropped", v, 32'd6);
    repeat (10) @(negedge clk);
    rd(8'h08, v); chk("R3 result of first operand", v, 32'd720);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(8'h08, 32'd4);
    wr(8'h20, 32'h0000_0080);
    rd(8'h20, v); chk("R6 enable set while busy keeps busy", v, 32'h81);
    repeat (8) @(negedge clk);
    rd(8'h20, v); chk("R6 enable sticks after finish", v, 32'h80);
    wr(8'h20, 32'hFFFF_FF7F);
    rd(8'h20, v); chk("R6 enable cleared, busy not set", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R8 unmapped read", v, 32'h0);
    rd(8'h08, v); chk("R8 data untouched", v, 32'd24);
    rd(8'h20, v); chk("R8 status untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    run_fact(32'd0, 1'b0);
    run_fact(32'd1, 1'b0);
    run_fact(32'd5, 1'b0);
    t_busy_write();
    t_status();
    t_unmapped();
    wr(8'h20, 32'h80);
    run_fact(32'd12, 1'b1);
    run_fact(32'd13, 1'b1);
    chk("R4 wraparound 13", fact_ref(32'd13), 32'd1932053504);
    run_fact(32'd0, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule